// File: doc/BRIEF.md
# MSI Queue Writer

This block collects message-signalled interrupts and turns each one into a 16-byte record in a circular queue that lives in system memory. An incoming message carries a data word. The low 16 bits of that word name the interrupt. For each message the block accepts, it issues one write request on a simple valid/ready memory port. The write address is the programmed 64-bit queue base plus the current write offset. After the memory side accepts the request, the write offset moves forward by one record and wraps at the end of the queue.

The host drains the queue in software. It reads records from memory and then writes its own read offset into the block. The block raises a level interrupt while the queue holds unread records. When the queue fills, one control bit decides what happens next. Either the message input stalls until the host frees space, or the message is dropped. A dropped message can set a sticky overflow flag, which the host clears by writing to the control register.

Top module: `msi_queue_writer`

## Requirements
- R1: After reset every register reads 0, and `irq_o`, `msg_ready_o` and `mem_valid_o` are low.
- R2: The register offsets are: 0 for control, 3 for the upper base word, 4 for the lower base word, 5 for the read offset and 6 for the write offset. Control bits are: 0 enable, 1 full handling, 3 interrupt enable, 4 stop-on-full, 9:8 size select. Other control bits read 0. Control bit 31 reads the overflow flag, and writing 1 to it clears the flag. Offset 6 ignores writes. Unmapped offsets read 0. A register write takes effect on the next clock edge, and reads are combinational.
- R3: Each record write carries address = {upper, lower} + write offset. The 128-bit data holds the message's low 16 bits in bits 15:0, zero-extended, so they sit little-endian in the first 4 bytes. All other bits are zero.
- R4: The queue size is 2^(15+size select) bytes. Reads of the read and write offsets are masked to that size and to 16-byte alignment.
- R5: The write offset advances by 16 only on a memory handshake (valid and ready in the same cycle), and it wraps to 0 at the end of the queue.
- R6: `mem_valid_o`, `mem_addr_o` and `mem_data_o` hold until ready, unless enable is cleared. While a request is outstanding, `msg_ready_o` stays low.
- R7: The queue is full when (write offset + 16) modulo the size equals the read offset. While the queue is full and stop-on-full is set, `msg_ready_o` is low.
- R8: While the queue is full and stop-on-full is clear, a message is accepted but produces no memory write. The overflow flag is set only if full handling is enabled.
- R9: `irq_o` = enable AND interrupt enable AND (read offset ≠ write offset).
- R10: With enable clear, no message is accepted and any outstanding request is withdrawn. Registers remain readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| msg_valid_i | input | 1 | Incoming message valid |
| msg_ready_o | output | 1 | Message accepted when high with valid |
| msg_data_i | input | 32 | Message data word |
| mem_valid_o | output | 1 | Record write request valid |
| mem_ready_i | input | 1 | Memory accepts request |
| mem_addr_o | output | 64 | Record byte address |
| mem_data_o | output | 128 | Record contents |
| irq_o | output | 1 | Queue-not-empty interrupt |

## Verification
The bench targets these corner cases:
- **Full boundary.** A full test placed one record short of the read offset catches two faults: a design that compares the offsets directly overwrites unread records, and one off by a record stalls early.
- **Drop path.** The drop case catches a design that still issues a memory write, or one that sets the overflow flag with full handling off.
- **Wrap.** A full wrap over 2048 records, with a memory that stalls at intervals, catches a design that leaks the write offset past the queue bound, and one that moves the offset before the handshake.
- **Size change.** Changing the size select catches unmasked readback.
- **Disable mid-request.** Clearing enable while a request is pending catches a design that keeps writing to memory.

// File: rtl/msiq_pkg.sv
package msiq_pkg;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 2 * REG_W;
  localparam int REC_BYTES  = 16;
  localparam int REC_W      = 8 * REC_BYTES;
  localparam int SEL_W      = 2;
  localparam int REG_AW     = 3;

  localparam logic [REG_AW-1:0] REG_CTRL    = 3'd0;
  localparam logic [REG_AW-1:0] REG_BASE_HI = 3'd3;
  localparam logic [REG_AW-1:0] REG_BASE_LO = 3'd4;
  localparam logic [REG_AW-1:0] REG_RD_OFF  = 3'd5;
  localparam logic [REG_AW-1:0] REG_WR_OFF  = 3'd6;

  localparam int CTL_EN      = 0;
  localparam int CTL_FULL    = 1;
  localparam int CTL_IRQ     = 3;
  localparam int CTL_STOP    = 4;
  localparam int CTL_SIZE_LO = 8;
  localparam int CTL_OVF     = 31;

  typedef struct packed {
    logic             en;
    logic             full_en;
    logic             irq_en;
    logic             stop_en;
    logic [SEL_W-1:0] size_sel;
  } ctrl_t;
endpackage

// File: rtl/msiq_regs.sv
module msiq_regs
  import msiq_pkg::*;
#(
  parameter int OFF_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              ovf_set_i,
  input  logic [OFF_W-1:0]  mask_i,
  input  logic [OFF_W-1:0]  wr_eff_i,
  output ctrl_t             ctrl_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [OFF_W-1:0]  rd_raw_o
);
  ctrl_t             ctrl_q;
  logic [REG_W-1:0]  hi_q, lo_q;
  logic [OFF_W-1:0]  rd_q;
  logic              ovf_q;
  logic              ctrl_wr;

  assign ctrl_wr = we_i && (addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      rd_q   <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (we_i) begin
        case (addr_i)
          REG_CTRL: begin
            ctrl_q.en       <= wdata_i[CTL_EN];
            ctrl_q.full_en  <= wdata_i[CTL_FULL];
            ctrl_q.irq_en   <= wdata_i[CTL_IRQ];
            ctrl_q.stop_en  <= wdata_i[CTL_STOP];
            ctrl_q.size_sel <= wdata_i[CTL_SIZE_LO +: SEL_W];
          end
          REG_BASE_HI: hi_q <= wdata_i;
          REG_BASE_LO: lo_q <= wdata_i;
          REG_RD_OFF:  rd_q <= wdata_i[OFF_W-1:0];
          default: ;
        endcase
      end
      // set wins over a clear in the same cycle
      if (ovf_set_i)                    ovf_q <= 1'b1;
      else if (ctrl_wr && wdata_i[CTL_OVF]) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: begin
        rdata_o[CTL_EN]                 = ctrl_q.en;
        rdata_o[CTL_FULL]               = ctrl_q.full_en;
        rdata_o[CTL_IRQ]                = ctrl_q.irq_en;
        rdata_o[CTL_STOP]               = ctrl_q.stop_en;
        rdata_o[CTL_SIZE_LO +: SEL_W]   = ctrl_q.size_sel;
        rdata_o[CTL_OVF]                = ovf_q;
      end
      REG_BASE_HI: rdata_o = hi_q;
      REG_BASE_LO: rdata_o = lo_q;
      REG_RD_OFF:  rdata_o[OFF_W-1:0] = rd_q & mask_i;
      REG_WR_OFF:  rdata_o[OFF_W-1:0] = wr_eff_i;
      default: ;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign base_o   = {hi_q, lo_q};
  assign rd_raw_o = rd_q;

  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ctrl_wr) |=> ovf_q);
endmodule

// File: rtl/msiq_ptr.sv
module msiq_ptr
  import msiq_pkg::*;
#(
  parameter int MIN_SHIFT = 15,
  parameter int OFF_W     = MIN_SHIFT + (1 << SEL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] size_sel_i,
  input  logic [OFF_W-1:0] rd_raw_i,
  input  logic             adv_i,
  output logic [OFF_W-1:0] mask_o,
  output logic [OFF_W-1:0] wr_eff_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int SEL_MAX = (1 << SEL_W) - 1;

  logic [OFF_W-1:0] wr_q, rd_eff, wr_nxt;

  assign mask_o   = ({OFF_W{1'b1}} >> (SEL_MAX - int'(size_sel_i))) & ~OFF_W'(REC_BYTES - 1);
  assign wr_eff_o = wr_q & mask_o;
  assign rd_eff   = rd_raw_i & mask_o;
  assign wr_nxt   = (wr_eff_o + OFF_W'(REC_BYTES)) & mask_o;
  assign full_o   = (wr_nxt == rd_eff);
  assign empty_o  = (wr_eff_o == rd_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wr_q <= '0;
    else if (adv_i) wr_q <= wr_nxt;
  end

  // R5
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(wr_q));
endmodule

// File: rtl/msiq_wr.sv
module msiq_wr
  import msiq_pkg::*;
#(
  parameter int OFF_W = 18,
  parameter int ID_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              stop_en_i,
  input  logic              full_en_i,
  input  logic              full_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  wr_eff_i,
  input  logic              msg_valid_i,
  input  logic [ID_W-1:0]   msg_id_i,
  output logic              msg_ready_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [REC_W-1:0]  mem_data_o,
  output logic              adv_o,
  output logic              ovf_set_o
);
  logic              busy_q, take;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q;

  assign msg_ready_o = en_i && !busy_q && !(full_i && stop_en_i);
  assign take        = msg_valid_i && msg_ready_o;
  assign ovf_set_o   = take && full_i && full_en_i;
  assign mem_valid_o = busy_q && en_i;
  assign adv_o       = mem_valid_o && mem_ready_i;
  assign mem_addr_o  = addr_q;
  assign mem_data_o  = {{(REC_W - ID_W){1'b0}}, id_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      id_q   <= '0;
      addr_q <= '0;
    end else if (busy_q) begin
      if (!en_i || mem_ready_i) busy_q <= 1'b0;
    end else if (take && !full_i) begin
      busy_q <= 1'b1;
      id_q   <= msg_id_i;
      addr_q <= base_i + ADDR_W'(wr_eff_i);
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> ((mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)) || !en_i));
  // R6
  one_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !msg_ready_o);
  // R10
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!mem_valid_o && !msg_ready_o));
endmodule

// File: rtl/msi_queue_writer.sv
module msi_queue_writer
  import msiq_pkg::*;
#(
  parameter int MIN_SHIFT = 15,
  parameter int ID_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              msg_valid_i,
  output logic              msg_ready_o,
  input  logic [31:0]       msg_data_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [63:0]       mem_addr_o,
  output logic [127:0]      mem_data_o,
  output logic              irq_o
);
  localparam int OFF_W = MIN_SHIFT + (1 << SEL_W) - 1;

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] base;
  logic [OFF_W-1:0]  rd_raw, mask, wr_eff;
  logic              full, empty, adv, ovf_set;

  msiq_regs #(.OFF_W(OFF_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .ovf_set_i(ovf_set), .mask_i(mask), .wr_eff_i(wr_eff),
    .ctrl_o(ctrl), .base_o(base), .rd_raw_o(rd_raw)
  );

  msiq_ptr #(.MIN_SHIFT(MIN_SHIFT), .OFF_W(OFF_W)) u_ptr (
    .clk_i, .rst_ni,
    .size_sel_i(ctrl.size_sel), .rd_raw_i(rd_raw), .adv_i(adv),
    .mask_o(mask), .wr_eff_o(wr_eff), .full_o(full), .empty_o(empty)
  );

  msiq_wr #(.OFF_W(OFF_W), .ID_W(ID_W)) u_wr (
    .clk_i, .rst_ni,
    .en_i(ctrl.en), .stop_en_i(ctrl.stop_en), .full_en_i(ctrl.full_en), .full_i(full),
    .base_i(base), .wr_eff_i(wr_eff),
    .msg_valid_i, .msg_id_i(msg_data_i[ID_W-1:0]), .msg_ready_o,
    .mem_valid_o, .mem_ready_i, .mem_addr_o, .mem_data_o,
    .adv_o(adv), .ovf_set_o(ovf_set)
  );

  assign irq_o = ctrl.en && ctrl.irq_en && !empty;

  // R4
  wr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == REG_WR_OFF) |->
      ((reg_rdata_o[3:0] == 4'd0) && ((reg_rdata_o >> (MIN_SHIFT + int'(ctrl.size_sel))) == 32'd0)));
  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctrl.en && ctrl.irq_en));
endmodule

// File: tb/msi_queue_writer_tb.sv
module msi_queue_writer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         reg_we_i = 1'b0;
  logic [2:0]   reg_addr_i = '0;
  logic [31:0]  reg_wdata_i = '0;
  logic [31:0]  reg_rdata_o;
  logic         msg_valid_i = 1'b0;
  logic         msg_ready_o;
  logic [31:0]  msg_data_i = '0;
  logic         mem_valid_o;
  logic         mem_ready_i = 1'b0;
  logic [63:0]  mem_addr_o;
  logic [127:0] mem_data_o;
  logic         irq_o;

  msi_queue_writer dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, fails = 0, cyc = 0, rdy_mode = 1;
  bit done = 0;

  // reference model state
  logic [31:0] m_ctrl, m_hi, m_lo;
  int          m_rd, m_wr;
  bit          m_busy, m_ovf;
  logic [15:0] m_id;
  logic [63:0] m_addr;

  function automatic int msk(int sel);
    return ((1 << (15 + sel)) - 1) & ~15;
  endfunction

  function automatic int cur_mask();
    return msk(int'(m_ctrl[9:8]));
  endfunction

  function automatic bit m_full();
    int mk = cur_mask();
    return (((m_wr & mk) + 16) & mk) == (m_rd & mk);
  endfunction

  function automatic bit exp_ready();
    return m_ctrl[0] && !m_busy && !(m_full() && m_ctrl[4]);
  endfunction

  function automatic logic [31:0] exp_rdata(logic [2:0] a);
    case (a)
      3'd0: return m_ctrl | (32'(m_ovf) << 31);
      3'd3: return m_hi;
      3'd4: return m_lo;
      3'd5: return 32'(m_rd & cur_mask());
      3'd6: return 32'(m_wr & cur_mask());
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic report();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // model update at each edge, from inputs stable since the previous falling edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = 0; m_hi = 0; m_lo = 0; m_rd = 0; m_wr = 0;
      m_busy = 0; m_ovf = 0; m_id = 0; m_addr = 0;
    end else begin
      bit en, set, full, rdy;
      int mk;
      en = m_ctrl[0]; mk = cur_mask(); full = m_full(); rdy = exp_ready(); set = 0;
      if (m_busy) begin
        if (!en) m_busy = 0;
        else if (mem_ready_i) begin
          m_wr = ((m_wr & mk) + 16) & mk;
          m_busy = 0;
        end
      end else if (msg_valid_i && rdy) begin
        if (full) set = m_ctrl[1];
        else begin
          m_busy = 1;
          m_id = msg_data_i[15:0];
          m_addr = {m_hi, m_lo} + 64'(m_wr & mk);
        end
      end
      if (reg_we_i) begin
        case (reg_addr_i)
          3'd0: begin
            m_ctrl = reg_wdata_i & 32'h0000_031B;
            if (reg_wdata_i[31]) m_ovf = 0;
          end
          3'd3: m_hi = reg_wdata_i;
          3'd4: m_lo = reg_wdata_i;
          3'd5: m_rd = int'(reg_wdata_i & 32'h3FFFF);
          default: ;
        endcase
      end
      if (set) m_ovf = 1;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit ev, ei;
      ev = m_busy && m_ctrl[0];
      ei = m_ctrl[0] && m_ctrl[3] && ((m_rd & cur_mask()) != (m_wr & cur_mask()));
      chk(irq_o == ei, "R9 irq_o", 128'(irq_o), 128'(ei));
      chk(msg_ready_o == exp_ready(), "R7 msg_ready_o", 128'(msg_ready_o), 128'(exp_ready()));
      chk(mem_valid_o == ev, "R6 mem_valid_o", 128'(mem_valid_o), 128'(ev));
      if (ev) begin
        chk(mem_addr_o == m_addr, "R3 mem_addr_o", 128'(mem_addr_o), 128'(m_addr));
        chk(mem_data_o == 128'(m_id), "R3 mem_data_o", mem_data_o, 128'(m_id));
      end
      chk(reg_rdata_o == exp_rdata(reg_addr_i), "R2 reg_rdata_o",
          128'(reg_rdata_o), 128'(exp_rdata(reg_addr_i)));
    end
  end

  always @(negedge clk_i) begin
    #1;
    case (rdy_mode)
      0: mem_ready_i = 1'b0;
      1: mem_ready_i = 1'b1;
      default: mem_ready_i = (cyc % 3) != 0;
    endcase
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired got=%0d exp=0", cyc);
      report();
    end
  end

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i); #1;
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); #1;
    reg_we_i = 0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i); #1;
    reg_addr_i = a;
    @(negedge clk_i);
    d = reg_rdata_o;
  endtask

  task automatic send(logic [31:0] d, int tmo, output bit acc);
    bit r;
    int n = 0;
    @(negedge clk_i); #1;
    msg_valid_i = 1; msg_data_i = d;
    do begin
      r = msg_ready_o;
      @(negedge clk_i);
      n++;
    end while (!r && n < tmo);
    #1 msg_valid_i = 0;
    acc = r;
  endtask

  task automatic wait_idle();
    do @(negedge clk_i); while (mem_valid_o);
  endtask

  initial begin
    logic [31:0] v;
    bit acc;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    @(negedge clk_i);
    chk(!irq_o && !msg_ready_o && !mem_valid_o, "R1 outputs", 128'({irq_o, msg_ready_o, mem_valid_o}), 0);
    for (int a = 0; a < 8; a++) begin
      reg_rd(3'(a), v);
      chk(v == 0, "R1 reg reset", 128'(v), 0);
    end
    // R2 map, undefined bits, write-ignored offset
    reg_wr(3'd0, 32'h7FFF_FCE4);
    reg_rd(3'd0, v); chk(v == 0, "R2 undefined ctrl bits", 128'(v), 0);
    reg_wr(3'd6, 32'h0000_1230);
    reg_rd(3'd6, v); chk(v == 0, "R2 write offset ignores writes", 128'(v), 0);
    reg_wr(3'd3, 32'h0000_0001);
    reg_wr(3'd4, 32'h8000_0000);
    reg_rd(3'd3, v); chk(v == 32'h1, "R2 base hi", 128'(v), 128'h1);
    reg_rd(3'd4, v); chk(v == 32'h8000_0000, "R2 base lo", 128'(v), 128'h8000_0000);
    reg_wr(3'd1, 32'hFFFF_FFFF);
    reg_rd(3'd1, v); chk(v == 0, "R2 unmapped", 128'(v), 0);
    // R3 record contents and address
    reg_wr(3'd0, 32'h0000_001B);
    rdy_mode = 0;
    send(32'hABCD_1234, 10, acc);
    @(negedge clk_i);
    chk(mem_valid_o && mem_addr_o == 64'h1_8000_0000, "R3 first address", 128'(mem_addr_o), 128'h1_8000_0000);
    chk(mem_data_o == 128'h1234, "R3 record data", mem_data_o, 128'h1234);
    repeat (4) @(negedge clk_i);
    chk(mem_valid_o == 1, "R6 request held", 128'(mem_valid_o), 1);
    reg_rd(3'd6, v); chk(v == 0, "R5 no advance without handshake", 128'(v), 0);
    rdy_mode = 1;
    wait_idle();
    send(32'h0000_0002, 10, acc);
    send(32'h0000_0003, 10, acc);
    wait_idle();
    reg_rd(3'd6, v); chk(v == 32'h30, "R5 advance by 16", 128'(v), 128'h30);
    chk(irq_o == 1, "R9 irq pending", 128'(irq_o), 1);
    // R7 stall on full
    reg_wr(3'd5, 32'h50);
    send(32'h4, 10, acc);
    wait_idle();
    send(32'h5, 12, acc);
    chk(acc == 0, "R7 stalled while full", 128'(acc), 0);
    reg_rd(3'd6, v); chk(v == 32'h40, "R7 offset held at full", 128'(v), 128'h40);
    // R8 drop on full
    reg_wr(3'd0, 32'h0000_000B);
    send(32'h6, 10, acc);
    chk(acc == 1, "R8 dropped message accepted", 128'(acc), 1);
    repeat (3) @(negedge clk_i);
    reg_rd(3'd6, v); chk(v == 32'h40, "R8 no write on drop", 128'(v), 128'h40);
    reg_rd(3'd0, v); chk(v == 32'h8000_000B, "R8 overflow set", 128'(v), 128'h8000_000B);
    reg_wr(3'd0, 32'h8000_000B);
    reg_rd(3'd0, v); chk(v == 32'h0000_000B, "R2 overflow cleared", 128'(v), 128'hB);
    reg_wr(3'd0, 32'h0000_0009);
    send(32'h7, 10, acc);
    repeat (2) @(negedge clk_i);
    reg_rd(3'd0, v); chk(v == 32'h9, "R8 no overflow when full handling off", 128'(v), 128'h9);
    // R9 empty -> no irq
    reg_wr(3'd5, 32'h40);
    @(negedge clk_i);
    chk(irq_o == 0, "R9 empty queue", 128'(irq_o), 0);
    // R5 wrap over the whole 32 KB queue with a stalling memory
    reg_wr(3'd0, 32'h0000_001B);
    rdy_mode = 2;
    for (int i = 0; i < 2048; i++) begin
      send(32'(i), 50, acc);
      if (i % 512 == 511) begin
        wait_idle();
        reg_rd(3'd6, v);
        reg_wr(3'd5, v);
      end
    end
    wait_idle();
    reg_rd(3'd6, v); chk(v == 32'h40, "R5 wrap back to start", 128'(v), 128'h40);
    // R4 size select masking
    rdy_mode = 1;
    reg_wr(3'd0, 32'h0000_031B);
    reg_wr(3'd5, 32'h0003_FFFF);
    reg_rd(3'd5, v); chk(v == 32'h3_FFF0, "R4 256 KB mask", 128'(v), 128'h3FFF0);
    reg_wr(3'd0, 32'h0000_011B);
    reg_rd(3'd5, v); chk(v == 32'hFFF0, "R4 64 KB mask", 128'(v), 128'hFFF0);
    send(32'h55, 10, acc);
    wait_idle();
    reg_rd(3'd6, v); chk(v == 32'h50, "R4 offset within 64 KB", 128'(v), 128'h50);
    // R10 disable withdraws request, registers stay live
    rdy_mode = 0;
    send(32'h66, 10, acc);
    @(negedge clk_i);
    reg_wr(3'd0, 32'h0000_011A);
    @(negedge clk_i);
    chk(mem_valid_o == 0, "R10 request withdrawn", 128'(mem_valid_o), 0);
    send(32'h77, 8, acc);
    chk(acc == 0, "R10 no accept while disabled", 128'(acc), 0);
    reg_wr(3'd4, 32'h1234_5670);
    reg_rd(3'd4, v); chk(v == 32'h1234_5670, "R10 registers live", 128'(v), 128'h12345670);
    reg_rd(3'd6, v); chk(v == 32'h50, "R10 no advance", 128'(v), 128'h50);
    repeat (3) @(negedge clk_i);
    report();
  end
endmodule